// File: doc/BRIEF.md
# GF(4096) Tower-Field Multiplier

This block multiplies two 12-bit elements of GF(4096). Each element is held as a pair of GF(64) elements: a 6-bit upper half and a 6-bit lower half. The field is the quadratic extension of GF(64) by x^2 + x + c, where c = 0x21 is the inverse of the generator of GF(64). The base field GF(64) is reduced by x^6 + x + 1. The product is built from four GF(64) sub-multipliers, each an unrolled six-step shift-and-add network. No polynomial-basis reduction over twelve bits is needed.

A parameter picks one of two builds. In the first, the product and its valid flag are registered, giving one cycle of latency. In the second, the block is purely combinational and the valid flag passes straight through. Typical users are Reed-Solomon syndrome and error-locator datapaths that work on 12-bit symbols.

Top module: `gf_tower_mul`

## Requirements
- R1: An operand's bits 11:6 are its upper GF(64) half and bits 5:0 are its lower half. The product is the upper result half placed in bits 11:6 and the lower result half in bits 5:0.
- R2: The upper result half equals (aHi^aLo)*(bHi^bLo) ^ aLo*bLo, with both products taken in GF(64).
- R3: The lower result half equals (aHi*bHi)*0x21 ^ aLo*bLo in GF(64). For example, 0x040 * 0x040 = 0x061 and 0x080 * 0x080 = 0x102.
- R4: GF(64) products are reduced by x^6 + x + 1. For example, 0x002 * 0x020 = 0x003.
- R5: If either operand is 0x000, the product is 0x000.
- R6: If either operand is 0x001, the product equals the other operand.
- R7: With OUT_REG=1, the product and outValid appear one clock after a cycle in which inValid is high. outValid equals inValid delayed by one clock.
- R8: With OUT_REG=1, a cycle with inValid low leaves product unchanged on the next clock, whatever the operands are.
- R9: With OUT_REG=0, product follows the operands in the same cycle and outValid equals inValid.
- R10: While rstN is low, a registered build holds outValid at 0 and product at 0x000.
- R11: The product is commutative: a*b equals b*a.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands on opA/opB are valid this cycle |
| opA | input | 12 | First GF(4096) operand |
| opB | input | 12 | Second GF(4096) operand |
| outValid | output | 1 | product is valid |
| product | output | 12 | GF(4096) product |

## Verification
The bench builds two copies of the block side by side, one with OUT_REG=1 and one with OUT_REG=0. Both copies receive the same operands, so every vector is checked in the same cycle on the combinational copy and one clock later on the registered copy. This brings both the latency and hold behaviour (R7, R8, R10) and the pass-through valid (R9) within reach. Both copies keep the default field constants, and the zero and unit operand cases are swept over all 4096 values on both.

// File: rtl/gf_tower_pkg.sv
package gf_tower_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture the combinational product into the output register
    logic bypass;   // drive the combinational product straight to the port
  } towerStrobe_t;

endpackage

// File: rtl/gf64_mul.sv
module gf64_mul #(
  parameter int          HALF_W   = 6,
  parameter logic [5:0]  POLY_LOW = 6'h03   // x^6 + x + 1 without the top term
) (
  input  logic [HALF_W-1:0] a,
  input  logic [HALF_W-1:0] b,
  output logic [HALF_W-1:0] y
);

  localparam int STEPS = HALF_W;

  logic [STEPS:0][HALF_W-1:0] accum;
  logic [STEPS:0][HALF_W-1:0] shifted;

  assign accum[0]   = '0;
  assign shifted[0] = b;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign accum[i+1]   = accum[i] ^ (a[i] ? shifted[i] : '0);
    assign shifted[i+1] = {shifted[i][HALF_W-2:0], 1'b0}
                        ^ (shifted[i][HALF_W-1] ? POLY_LOW[HALF_W-1:0] : '0);
  end

  assign y = accum[STEPS];

endmodule

// File: rtl/gf_tower_ctrl.sv
module gf_tower_ctrl
  import gf_tower_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output towerStrobe_t strobe,
  output logic         outValid
);

  if (OUT_REG) begin : g_reg
    logic validQ;
    always_ff @(posedge clk) begin
      if (!rstN) validQ <= 1'b0;
      else       validQ <= inValid;
    end
    assign strobe.loadEn = inValid;
    assign strobe.bypass = 1'b0;
    assign outValid      = validQ;
  end else begin : g_comb
    assign strobe.loadEn = 1'b0;
    assign strobe.bypass = 1'b1;
    assign outValid      = inValid;
  end

endmodule

// File: rtl/gf_tower_datapath.sv
module gf_tower_datapath
  import gf_tower_pkg::*;
#(
  parameter int         HALF_W    = 6,
  parameter logic [5:0] POLY_LOW  = 6'h03,
  parameter logic [5:0] EXT_CONST = 6'h21,
  localparam int        ELEM_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  towerStrobe_t      strobe,
  input  logic [ELEM_W-1:0] opA,
  input  logic [ELEM_W-1:0] opB,
  output logic [ELEM_W-1:0] product
);

  logic [HALF_W-1:0] aHi, aLo, bHi, bLo;
  logic [HALF_W-1:0] loLo, sumSum, hiHi, hiHiScaled;
  logic [HALF_W-1:0] resHi, resLo;
  logic [ELEM_W-1:0] combProd, prodQ;

  assign aHi = opA[ELEM_W-1:HALF_W];
  assign aLo = opA[HALF_W-1:0];
  assign bHi = opB[ELEM_W-1:HALF_W];
  assign bLo = opB[HALF_W-1:0];

  gf64_mul #(.HALF_W(HALF_W), .POLY_LOW(POLY_LOW)) u_mulLo (
    .a(aLo), .b(bLo), .y(loLo));

  gf64_mul #(.HALF_W(HALF_W), .POLY_LOW(POLY_LOW)) u_mulSum (
    .a(aHi ^ aLo), .b(bHi ^ bLo), .y(sumSum));

  gf64_mul #(.HALF_W(HALF_W), .POLY_LOW(POLY_LOW)) u_mulHi (
    .a(aHi), .b(bHi), .y(hiHi));

  gf64_mul #(.HALF_W(HALF_W), .POLY_LOW(POLY_LOW)) u_mulExt (
    .a(hiHi), .b(EXT_CONST[HALF_W-1:0]), .y(hiHiScaled));

  assign resHi    = sumSum ^ loLo;
  assign resLo    = hiHiScaled ^ loLo;
  assign combProd = {resHi, resLo};

  always_ff @(posedge clk) begin
    if (!rstN)              prodQ <= '0;
    else if (strobe.loadEn) prodQ <= combProd;
  end

  assign product = strobe.bypass ? combProd : prodQ;

endmodule

// File: rtl/gf_tower_mul.sv
module gf_tower_mul
  import gf_tower_pkg::*;
#(
  parameter int         HALF_W    = 6,
  parameter logic [5:0] POLY_LOW  = 6'h03,
  parameter logic [5:0] EXT_CONST = 6'h21,
  parameter bit         OUT_REG   = 1'b1,
  localparam int        ELEM_W    = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ELEM_W-1:0] opA,
  input  logic [ELEM_W-1:0] opB,
  output logic              outValid,
  output logic [ELEM_W-1:0] product
);

  towerStrobe_t strobe;

  gf_tower_ctrl #(.OUT_REG(OUT_REG)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid));

  gf_tower_datapath #(
    .HALF_W(HALF_W), .POLY_LOW(POLY_LOW), .EXT_CONST(EXT_CONST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .opA(opA), .opB(opB), .product(product));

endmodule

// File: rtl/gf_tower_mul_chk.sv
module gf_tower_mul_chk #(
  parameter bit OUT_REG = 1'b1,
  parameter int ELEM_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [ELEM_W-1:0] opA,
  input logic [ELEM_W-1:0] opB,
  input logic              outValid,
  input logic [ELEM_W-1:0] product
);

  localparam logic [ELEM_W-1:0] UNIT = ELEM_W'(1);

  if (OUT_REG) begin : g_reg
    // R5
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && (opA == '0 || opB == '0)) |=> (product == '0));
    // R6
    unit_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && opA == UNIT) |=> (product == $past(opB)));
    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (outValid == $past(inValid)));
    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(product));
  end else begin : g_comb
    // R5
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
      (opA == '0 || opB == '0) |-> (product == '0));
    // R6
    unit_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
      (opB == UNIT) |-> (product == opA));
    // R9
    comb_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid);
  end

endmodule

bind gf_tower_mul gf_tower_mul_chk #(.OUT_REG(OUT_REG), .ELEM_W(ELEM_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
  .outValid(outValid), .product(product));

// File: tb/gf_tower_mul_bench.sv
`timescale 1ns/1ps
module gf_tower_mul_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [11:0] opA = '0, opB = '0;
  logic        regValid, combValid;
  logic [11:0] regProd, combProd;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gf_tower_mul #(.OUT_REG(1'b1)) u_gf_tower_mul (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(regValid), .product(regProd));

  gf_tower_mul #(.OUT_REG(1'b0)) u_gf_tower_mul_comb (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(combValid), .product(combProd));

  // reference: carry-less product then reduction from the top bit down
  function automatic logic [5:0] refMul64(input logic [5:0] x, input logic [5:0] y);
    logic [10:0] t = '0;
    for (int i = 0; i < 6; i++) if (y[i]) t ^= 11'(x) << i;
    for (int k = 10; k >= 6; k--) if (t[k]) t ^= 11'h043 << (k - 6);
    return t[5:0];
  endfunction

  function automatic logic [11:0] refMul(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] lo = refMul64(a[5:0], b[5:0]);
    logic [5:0] hi = refMul64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ lo;
    logic [5:0] l2 = refMul64(refMul64(a[11:6], b[11:6]), 6'h21) ^ lo;
    return {hi, l2};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one vector, check combinational copy now and registered copy after the edge
  task automatic runVec(input logic [11:0] a, input logic [11:0] b,
                        input logic [11:0] exp, input string req);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    #1;
    check({req, " comb R9"}, 32'(combProd), 32'(exp));
    @(posedge clk); #1;
    check({req, " reg R7"}, 32'(regProd), 32'(exp));
    check("R7 outValid", 32'(regValid), 32'd1);
  endtask

  // {a, b, expected}, worked out by hand from R3/R4/R6
  localparam logic [35:0] VECS [6] = '{
    {12'h040, 12'h040, 12'h061},   // R3
    {12'h080, 12'h080, 12'h102},   // R3
    {12'h002, 12'h020, 12'h003},   // R4
    {12'h040, 12'h001, 12'h040},   // R6
    {12'h001, 12'hABC, 12'hABC},   // R6
    {12'h000, 12'hFFF, 12'h000}    // R5
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] held;
    // R10: reset holds registered outputs low even with valid input
    opA = 12'h123; opB = 12'h456; inValid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R10 outValid", 32'(regValid), 32'd0);
    check("R10 product", 32'(regProd), 32'd0);
    @(negedge clk); rstN = 1'b1; inValid = 1'b0;

    for (int i = 0; i < 6; i++)
      runVec(VECS[i][35:24], VECS[i][23:12], VECS[i][11:0], "table R1");

    // R2/R3 against the model on spread operands
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a = 12'((i * 12'h9E3) ^ (i << 3) ^ 12'h5A5);
      logic [11:0] b = 12'((i * 12'h3B1) + 12'h0F7);
      runVec(a, b, refMul(a, b), "model R2 R3");
    end

    // R11 commutativity
    for (int i = 1; i < 64; i++) begin
      logic [11:0] a = 12'(i * 61);
      logic [11:0] b = 12'(i * 197 + 5);
      runVec(b, a, refMul(a, b), "swap R11");
    end

    // R5 and R6 exhaustive
    for (int v = 0; v < 4096; v++) runVec(12'(v), 12'h000, 12'h000, "zero R5");
    for (int v = 0; v < 4096; v++) runVec(12'h001, 12'(v), 12'(v), "unit R6");

    // R8 hold: inValid low, operands change, registered product keeps last value
    runVec(12'h0C3, 12'h7E1, refMul(12'h0C3, 12'h7E1), "pre-hold R8");
    held = refMul(12'h0C3, 12'h7E1);
    @(negedge clk);
    opA = 12'h555; opB = 12'h333; inValid = 1'b0;
    #1;
    check("R9 comb outValid low", 32'(combValid), 32'd0);
    @(posedge clk); #1;
    check("R8 product held", 32'(regProd), 32'(held));
    check("R7 outValid low", 32'(regValid), 32'd0);
    @(posedge clk); #1;
    check("R8 product still held", 32'(regProd), 32'(held));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule